// File: doc/BRIEF.md
# Mains Sector and Injection-Phase Selector

This block watches three sampled mains phase voltages, given as signed fixed-point words with a one-cycle valid strobe. It places the present mains angle in one of twelve 30-degree sectors. It reports which phase holds the largest value and which holds the smallest, so that the PWM stage knows which phases its positive and negative fast switches serve. It also drives the enables of three bidirectional current-injection switches. Injection goes into the phase of smallest magnitude, which is the phase whose value lies between the other two.

Two measures keep the low-frequency injection switches well behaved. First, a programmable hysteresis margin stops the selection from chattering where two phase magnitudes cross. Second, on every change of injection phase the old enable is removed before the new one is applied, with a programmable number of idle cycles in between, so that two injection switches never conduct at the same time.

Top module: `mains_sector_sel`

## Requirements
- R1: While reset is asserted, and after reset until the first cycle in which `smp_vld` is high, `sector` is 0 and `inj_en`, `max_oh` and `min_oh` are all 0.
- R2: `sector` is set from the sample as follows. The ordering of max/min phases gives an index k: (a,c)=0, (b,c)=1, (b,a)=2, (c,a)=3, (c,b)=4, (a,b)=5. The middle phase counts as negative when its sign bit is set. For even k the sector is 2k+1 if the middle phase is negative and 2k+2 otherwise. For odd k the sector is 2k+1 if the middle phase is non-negative and 2k+2 otherwise. So a>b>c with b<0 gives 1, and a=b=c=0 gives 2.
- R3: `max_oh` and `min_oh` are one-hot, with bit 0 for phase a, bit 1 for b and bit 2 for c. On ties the maximum prefers a, then b, then c. The minimum prefers c, then b, then a. The two never name the same phase.
- R4: `sector`, `max_oh` and `min_oh` update only on the clock edge at which `smp_vld` is high. They are visible from the next cycle and hold their value while `smp_vld` is low, whatever the phase inputs do.
- R5: The first valid sample after reset selects its middle phase directly, without hysteresis. That enable asserts on the same edge that registers the sample.
- R6: At most one bit of `inj_en` is high in any cycle.
- R7: After the first sample, the selected injection phase moves to the new middle phase only if |middle| + `hyst` is strictly less than |currently selected phase|, both taken from the same sample. Equality keeps the old selection.
- R8: When the selection changes while an enable is high, `inj_en` goes to 0 on the edge that registers the sample. It stays 0 for `dead_cycles`+1 cycles, and then the new phase's enable asserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Phase samples valid this cycle |
| va | input | W | Phase a voltage, signed |
| vb | input | W | Phase b voltage, signed |
| vc | input | W | Phase c voltage, signed |
| hyst | input | W | Unsigned magnitude margin for reselection |
| dead_cycles | input | CW | Idle count between enables on a handover |
| sector | output | 4 | Mains sector 1..12, 0 before first sample |
| inj_en | output | 3 | Injection switch enables, bit 0 = phase a |
| max_oh | output | 3 | One-hot phase holding the largest value |
| min_oh | output | 3 | One-hot phase holding the smallest value |

## Verification
The properties assume that `hyst` and `dead_cycles` are changed only while no handover is in progress. They also assume that `smp_vld` is high for exactly the cycles that carry a new sample. The stimulus follows this: it presents each sample as a single-cycle strobe, sets the margin and the dead count during reset, and changes the dead count only while one enable has been steady for some time. Phase words are kept within the signed range, including all-equal and exactly-at-margin cases. These cases exercise the tie-break and comparison edges.

// File: rtl/mains_sector_sel.sv
module mains_sector_sel #(
  parameter int W  = 12,
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] va,
  input  logic signed [W-1:0] vb,
  input  logic signed [W-1:0] vc,
  input  logic        [W-1:0] hyst,
  input  logic       [CW-1:0] dead_cycles,
  output logic          [3:0] sector,
  output logic          [2:0] inj_en,
  output logic          [2:0] max_oh,
  output logic          [2:0] min_oh
);
  localparam int MW = W + 1;
  localparam int SW = W + 2;

  function automatic logic [MW-1:0] mag(input logic signed [W-1:0] v);
    logic [MW-1:0] e;
    e = {v[W-1], v};
    return e[MW-1] ? (~e + 1'b1) : e;
  endfunction

  logic [2:0] mx, mn, md, tgt_q, tgt_d;
  logic [2:0] k;
  logic signed [W-1:0] vmid, vcur;
  logic neg, swap, seen_q;
  logic [3:0] sector_d;
  logic [CW-1:0] dt_q;

  assign mx = (va >= vb && va >= vc) ? 3'b001 : (vb >= vc ? 3'b010 : 3'b100);
  assign mn = (vc <= va && vc <= vb) ? 3'b100 : (vb <= va ? 3'b010 : 3'b001);
  assign md = ~(mx | mn);

  assign vmid = md[0] ? va : (md[1] ? vb : vc);
  assign vcur = tgt_q[0] ? va : (tgt_q[1] ? vb : vc);
  assign neg  = vmid[W-1];

  always_comb begin
    case ({mx, mn})
      6'b001_100: k = 3'd0;
      6'b010_100: k = 3'd1;
      6'b010_001: k = 3'd2;
      6'b100_001: k = 3'd3;
      6'b100_010: k = 3'd4;
      default:    k = 3'd5;
    endcase
  end

  assign sector_d = {k, 1'b0} + 4'd1 + {3'b000, ~(k[0] ^ neg)};

  assign swap  = (SW'(mag(vmid)) + SW'(hyst)) < SW'(mag(vcur));
  assign tgt_d = smp_vld ? ((!seen_q || swap) ? md : tgt_q) : tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      sector <= 4'd0;
      max_oh <= 3'b000;
      min_oh <= 3'b000;
      tgt_q  <= 3'b000;
      inj_en <= 3'b000;
      dt_q   <= '0;
    end else begin
      if (smp_vld) begin
        seen_q <= 1'b1;
        sector <= sector_d;
        max_oh <= mx;
        min_oh <= mn;
        tgt_q  <= tgt_d;
      end
      if (inj_en != 3'b000 && inj_en != tgt_d) begin
        inj_en <= 3'b000;
        dt_q   <= dead_cycles;
      end else if (inj_en == 3'b000 && (seen_q || smp_vld)) begin
        if (dt_q != '0) dt_q <= dt_q - 1'b1;
        else            inj_en <= tgt_d;
      end
    end
  end
endmodule

// File: rtl/mains_sector_sel_chk.sv
module mains_sector_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_vld,
  input logic [3:0] sector,
  input logic [2:0] inj_en,
  input logic [2:0] max_oh,
  input logic [2:0] min_oh
);
  AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (sector == 4'd0) |-> (inj_en == 3'b000 && max_oh == 3'b000 && min_oh == 3'b000)); // R1
  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sector <= 4'd12); // R2
  AST_MAXMIN_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sector != 4'd0) |-> ($onehot(max_oh) && $onehot(min_oh) && (max_oh & min_oh) == 3'b000)); // R3
  AST_HOLD_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(sector) && $stable(max_oh) && $stable(min_oh))); // R4
  AST_EN_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inj_en)); // R6
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_en != 3'b000) |=> (inj_en == 3'b000 || $stable(inj_en))); // R8
endmodule

bind mains_sector_sel mains_sector_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .sector(sector),
  .inj_en(inj_en), .max_oh(max_oh), .min_oh(min_oh)
);

// File: tb/tb_mains_sector_sel.sv
module tb_mains_sector_sel;
  localparam int W  = 12;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n, smp_vld;
  logic signed [W-1:0] va, vb, vc;
  logic [W-1:0] hyst;
  logic [CW-1:0] dead_cycles;
  logic [3:0] sector;
  logic [2:0] inj_en, max_oh, min_oh;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mains_sector_sel #(.W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .va(va), .vb(vb), .vc(vc),
    .hyst(hyst), .dead_cycles(dead_cycles), .sector(sector),
    .inj_en(inj_en), .max_oh(max_oh), .min_oh(min_oh)
  );

  // va, vb, vc, sector, max_oh, min_oh
  localparam int TV [13][6] = '{
    '{ 966, -259, -707,  1, 1, 4},
    '{ 707,  259, -966,  2, 1, 4},
    '{ 259,  707, -966,  3, 2, 4},
    '{-259,  966, -707,  4, 2, 4},
    '{-707,  966, -259,  5, 2, 1},
    '{-966,  707,  259,  6, 2, 1},
    '{-966,  259,  707,  7, 4, 1},
    '{-707, -259,  966,  8, 4, 1},
    '{-259, -707,  966,  9, 4, 2},
    '{ 259, -966,  707, 10, 4, 2},
    '{ 707, -966,  259, 11, 1, 2},
    '{ 966, -707, -259, 12, 1, 2},
    '{   0,    0,    0,  2, 1, 4}
  };

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    @(negedge clk);
    va = W'(a); vb = W'(b); vc = W'(c);
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_vld = 1'b0; va = '0; vb = '0; vc = '0;
    hyst = '0; dead_cycles = '0;
    repeat (3) @(negedge clk);
    chk("R1 sector in reset", int'(sector), 0);
    chk("R1 enables in reset", int'(inj_en), 0);
    rst_n = 1'b1;
    va = 12'sd500; vb = -12'sd100; vc = -12'sd400;
    repeat (3) @(negedge clk);
    chk("R1 sector before sample", int'(sector), 0);
    chk("R1 enables before sample", int'(inj_en), 0);
    chk("R1 max before sample", int'(max_oh), 0);
    chk("R1 min before sample", int'(min_oh), 0);

    for (int i = 0; i < 13; i++) begin
      apply(TV[i][0], TV[i][1], TV[i][2]);
      chk("R2 sector", int'(sector), TV[i][3]);
      chk("R3 max", int'(max_oh), TV[i][4]);
      chk("R3 min", int'(min_oh), TV[i][5]);
    end

    va = 12'sd500; vb = -12'sd900; vc = 12'sd400;
    repeat (3) @(negedge clk);
    chk("R4 sector held", int'(sector), 2);
    chk("R4 max held", int'(max_oh), 1);
    chk("R4 min held", int'(min_oh), 4);

    rst_n = 1'b0; hyst = 12'd100; dead_cycles = 8'd3;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply(800, -50, -750);
    chk("R5 first enable", int'(inj_en), 2);
    chk("R2 sector after reset", int'(sector), 1);

    apply(60, 140, -200);
    repeat (5) @(negedge clk);
    chk("R7 within margin keeps phase", int'(inj_en), 2);

    apply(30, 200, -230);
    chk("R8 old enable dropped", int'(inj_en), 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R8 dead time low", int'(inj_en), 0);
    end
    @(negedge clk);
    chk("R8 new enable", int'(inj_en), 1);

    apply(-130, 30, 100);
    repeat (4) @(negedge clk);
    chk("R7 equal margin keeps phase", int'(inj_en), 1);

    dead_cycles = 8'd0;
    repeat (2) @(negedge clk);
    apply(-200, 20, 180);
    chk("R8 zero dead drop", int'(inj_en), 0);
    @(negedge clk);
    chk("R8 zero dead new enable", int'(inj_en), 2);
    chk("R6 single enable", $countones(inj_en), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule